// File: doc/BRIEF.md
# Sampling-Array Readout Sequencer

This block runs one acquisition cycle of a switched-capacitor sampling array. A start strobe sets the array sampling. While sampling, a position counter follows the cell being written, advancing one cell per clock and wrapping at the array length. A trigger or a soft-stop strobe ends the sampling phase. The sequencer then latches the current cell position as the stop cell and walks a chosen range of channels. For every cell of every selected channel it issues one write into waveform memory, tagged with the channel and cell indices.

Two controls shape the readout. The first picks where each channel's walk begins: cell 0, or the latched stop cell with wraparound. The second decides whether the array keeps sampling while it is being read out. A busy flag covers the whole cycle, from the first sampling clock to the last memory write. A one-cycle done pulse then tells the host that the waveform memory holds a complete event. A reinit strobe abandons any phase and returns the sequencer to idle.

Top module: `sca_readout_seq`

## Requirements
- R1: After reset, busy_o, sampling_o, wr_en_o and done_o are 0 and stop_cell_o is 0.
- R2: A start_i pulse while idle makes sampling_o and busy_o 1 from the next cycle. The cell position is 0 in the first sampling cycle and advances by one per sampling cycle, modulo NUM_CELLS (1024).
- R3: A trig_i or soft_stop_i pulse during sampling latches the current cell position into stop_cell_o. Readout begins in the next cycle: wr_en_o is 1 with wr_ch_o equal to cfg_first_ch_i. If sampling ran for n cycles before the stop cycle, stop_cell_o equals n mod 1024.
- R4: With cfg_from_stop_i = 0, each channel is read at cells 0 to 1023 in ascending order. With cfg_from_stop_i = 1, each channel starts at stop_cell_o and ascends with wraparound modulo 1024. In both modes each channel gets exactly 1024 writes, one per cycle.
- R5: Channels are read in ascending order from cfg_first_ch_i to cfg_last_ch_i (4-bit addresses, 0..9). If the last address is below the first, only the first channel is read.
- R6: During readout, sampling_o equals cfg_keep_run_i.
- R7: busy_o is 1 in every sampling and readout cycle.
- R8: During readout, start_i, soft_stop_i and trig_i are ignored. The write sequence and stop_cell_o are unchanged.
- R9: reinit_i in any state makes busy_o, sampling_o and wr_en_o 0 in the next cycle. It raises no done_o and leaves stop_cell_o as it was.
- R10: done_o is 1 for exactly one cycle, the one right after the final write, and busy_o is 0 in that cycle.
- R11: trig_i and soft_stop_i are ignored while idle. busy_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-sampling strobe |
| reinit_i | input | 1 | Abort and return to idle |
| soft_stop_i | input | 1 | Software stop strobe |
| trig_i | input | 1 | Trigger, stops sampling |
| cfg_from_stop_i | input | 1 | 0: read from cell 0; 1: read from stop cell |
| cfg_keep_run_i | input | 1 | 1: keep sampling during readout |
| cfg_first_ch_i | input | 4 | First channel to read |
| cfg_last_ch_i | input | 4 | Last channel to read |
| sampling_o | output | 1 | Array is sampling |
| busy_o | output | 1 | Acquisition cycle in progress |
| wr_en_o | output | 1 | Waveform memory write strobe |
| wr_ch_o | output | 4 | Channel index of current write |
| wr_cell_o | output | 10 | Cell index of current write |
| stop_cell_o | output | 10 | Latched stop cell |
| done_o | output | 1 | One-cycle end-of-readout pulse |

## Verification
The hardest cases to reach are a stop cell past the wrap point, and stray strobes that land in the middle of a long readout. The directed scenarios let sampling run for more than 1024 cycles before triggering, so the latched position has wrapped. They then read in stop-cell mode and check every write index against the wrapped sequence. Another scenario pulses start, soft-stop and trigger midway through a channel walk and confirms that the sequence runs to completion. A further scenario fires reinit in the middle of a readout.

// File: rtl/sca_seq_pkg.sv
package sca_seq_pkg;

    localparam int DEF_NUM_CELLS = 1024;
    localparam int DEF_CH_W      = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_READ   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic stop_ev;
        logic go;
        logic abort;
    } seq_ctrl_t;

    function automatic logic [31:0] wrap_next(input logic [31:0] v, input int modulus);
        return (v == 32'(modulus - 1)) ? 32'd0 : v + 32'd1;
    endfunction

endpackage

// File: rtl/sca_pos_counter.sv
module sca_pos_counter
    import sca_seq_pkg::*;
#(
    parameter int NUM_CELLS = DEF_NUM_CELLS,
    localparam int CELL_W = $clog2(NUM_CELLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              adv_i,
    output logic [CELL_W-1:0] pos_o
);
    logic [CELL_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            pos_q <= '0;
        end else if (adv_i) begin
            pos_q <= CELL_W'(wrap_next(32'(pos_q), NUM_CELLS));
        end
    end

    assign pos_o = pos_q;
endmodule

// File: rtl/sca_read_walker.sv
module sca_read_walker
    import sca_seq_pkg::*;
#(
    parameter int NUM_CELLS = DEF_NUM_CELLS,
    parameter int CH_W      = DEF_CH_W,
    localparam int CELL_W = $clog2(NUM_CELLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [CH_W-1:0]   first_ch_i,
    input  logic [CH_W-1:0]   last_ch_i,
    input  logic [CELL_W-1:0] base_cell_i,
    output logic [CH_W-1:0]   ch_o,
    output logic [CELL_W-1:0] cell_o,
    output logic              all_end_o
);
    logic [CH_W-1:0]   ch_q, last_q;
    logic [CELL_W-1:0] cell_q, base_q, cnt_q;
    logic              chan_end;

    assign chan_end  = (cnt_q == CELL_W'(NUM_CELLS - 1));
    assign all_end_o = chan_end && (ch_q >= last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q   <= '0;
            last_q <= '0;
            cell_q <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            ch_q   <= first_ch_i;
            last_q <= last_ch_i;
            cell_q <= base_cell_i;
            base_q <= base_cell_i;
            cnt_q  <= '0;
        end else if (step_i) begin
            if (chan_end) begin
                ch_q   <= ch_q + 1'b1;
                cell_q <= base_q;
                cnt_q  <= '0;
            end else begin
                cell_q <= CELL_W'(wrap_next(32'(cell_q), NUM_CELLS));
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assign ch_o   = ch_q;
    assign cell_o = cell_q;
endmodule

// File: rtl/sca_readout_seq.sv
module sca_readout_seq
    import sca_seq_pkg::*;
#(
    parameter int NUM_CELLS = DEF_NUM_CELLS,
    parameter int CH_W      = DEF_CH_W,
    localparam int CELL_W = $clog2(NUM_CELLS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              reinit_i,
    input  logic              soft_stop_i,
    input  logic              trig_i,
    input  logic              cfg_from_stop_i,
    input  logic              cfg_keep_run_i,
    input  logic [CH_W-1:0]   cfg_first_ch_i,
    input  logic [CH_W-1:0]   cfg_last_ch_i,
    output logic              sampling_o,
    output logic              busy_o,
    output logic              wr_en_o,
    output logic [CH_W-1:0]   wr_ch_o,
    output logic [CELL_W-1:0] wr_cell_o,
    output logic [CELL_W-1:0] stop_cell_o,
    output logic              done_o
);
    seq_state_e        state_q;
    seq_ctrl_t         ctl;
    logic [CELL_W-1:0] pos, stop_q;
    logic              done_q, all_end;

    always_comb begin
        ctl.abort   = reinit_i;
        ctl.go      = (state_q == ST_IDLE) && start_i && !reinit_i;
        ctl.stop_ev = (state_q == ST_SAMPLE) && (trig_i || soft_stop_i) && !reinit_i;
    end

    assign sampling_o = (state_q == ST_SAMPLE) || ((state_q == ST_READ) && cfg_keep_run_i);
    assign busy_o     = (state_q != ST_IDLE);
    assign wr_en_o    = (state_q == ST_READ);

    sca_pos_counter #(.NUM_CELLS(NUM_CELLS)) u_pos (
        .clk     (clk),
        .rst     (rst),
        .clear_i (ctl.go),
        .adv_i   (sampling_o),
        .pos_o   (pos)
    );

    sca_read_walker #(.NUM_CELLS(NUM_CELLS), .CH_W(CH_W)) u_walk (
        .clk         (clk),
        .rst         (rst),
        .load_i      (ctl.stop_ev),
        .step_i      ((state_q == ST_READ) && !ctl.abort),
        .first_ch_i  (cfg_first_ch_i),
        .last_ch_i   (cfg_last_ch_i),
        .base_cell_i (cfg_from_stop_i ? pos : '0),
        .ch_o        (wr_ch_o),
        .cell_o      (wr_cell_o),
        .all_end_o   (all_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            stop_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ctl.abort) begin
                state_q <= ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE:   if (ctl.go) state_q <= ST_SAMPLE;
                    ST_SAMPLE: if (ctl.stop_ev) begin
                        state_q <= ST_READ;
                        stop_q  <= pos;
                    end
                    ST_READ:   if (all_end) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                    default:   state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign stop_cell_o = stop_q;
    assign done_o      = done_q;
endmodule

// File: rtl/sca_readout_seq_checker.sv
module sca_readout_seq_checker #(
    parameter int CELL_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              reinit_i,
    input logic              cfg_keep_run_i,
    input logic              sampling_o,
    input logic              busy_o,
    input logic              wr_en_o,
    input logic [CELL_W-1:0] stop_cell_o,
    input logic              done_o
);
    a_r7_write_while_busy: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> busy_o);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o && !wr_en_o);

    a_r9_reinit_idle: assert property (@(posedge clk) disable iff (rst)
        reinit_i |=> !busy_o && !wr_en_o && !sampling_o && !done_o);

    a_r8_stop_cell_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en_o) && wr_en_o) |-> $stable(stop_cell_o));

    a_r6_keep_run: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (sampling_o == cfg_keep_run_i));
endmodule

bind sca_readout_seq sca_readout_seq_checker #(.CELL_W(CELL_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .reinit_i       (reinit_i),
    .cfg_keep_run_i (cfg_keep_run_i),
    .sampling_o     (sampling_o),
    .busy_o         (busy_o),
    .wr_en_o        (wr_en_o),
    .stop_cell_o    (stop_cell_o),
    .done_o         (done_o)
);

// File: tb/sca_readout_seq_tb.sv
module sca_readout_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CELLS = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 0, reinit_i = 0, soft_stop_i = 0, trig_i = 0;
    logic cfg_from_stop_i = 0, cfg_keep_run_i = 0;
    logic [3:0] cfg_first_ch_i = 0, cfg_last_ch_i = 0;
    logic sampling_o, busy_o, wr_en_o, done_o;
    logic [3:0] wr_ch_o;
    logic [9:0] wr_cell_o, stop_cell_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sca_readout_seq dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .reinit_i(reinit_i),
        .soft_stop_i(soft_stop_i), .trig_i(trig_i),
        .cfg_from_stop_i(cfg_from_stop_i), .cfg_keep_run_i(cfg_keep_run_i),
        .cfg_first_ch_i(cfg_first_ch_i), .cfg_last_ch_i(cfg_last_ch_i),
        .sampling_o(sampling_o), .busy_o(busy_o), .wr_en_o(wr_en_o),
        .wr_ch_o(wr_ch_o), .wr_cell_o(wr_cell_o), .stop_cell_o(stop_cell_o),
        .done_o(done_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // start, n sampling cycles, then a stop strobe; leaves time at the first readout cycle
    task automatic launch(input int n, input bit use_soft);
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
        check("R2 sampling after start", int'(sampling_o), 1);
        check("R7 busy while sampling", int'(busy_o), 1);
        repeat (n) @(negedge clk);
        if (use_soft) soft_stop_i = 1; else trig_i = 1;
        @(negedge clk); soft_stop_i = 0; trig_i = 0;
    endtask

    // walk and verify the full readout; optional stray strobes at sample 100
    task automatic verify_readout(input int first, input int last, input bit from_stop,
                                  input bit keep, input int stopc, input bit inject);
        int nch = (last >= first) ? (last - first + 1) : 1;
        int bad_ch = 0, bad_cell = 0, bad_en = 0, bad_samp = 0, bad_stop = 0;
        for (int c = 0; c < nch; c++) begin
            for (int k = 0; k < CELLS; k++) begin
                int ec = from_stop ? ((stopc + k) % CELLS) : k;
                if (wr_en_o !== 1'b1) bad_en++;
                if (int'(wr_ch_o) != first + c) bad_ch++;
                if (int'(wr_cell_o) != ec) bad_cell++;
                if (sampling_o !== keep) bad_samp++;
                if (int'(stop_cell_o) != stopc) bad_stop++;
                if (inject && c == 0 && k == 100) begin
                    start_i = 1; soft_stop_i = 1; trig_i = 1;
                end
                @(negedge clk);
                start_i = 0; soft_stop_i = 0; trig_i = 0;
            end
        end
        check("R4 write strobe every cycle", bad_en, 0);
        check("R5 channel order", bad_ch, 0);
        check("R4 cell order", bad_cell, 0);
        check("R6 sampling during readout", bad_samp, 0);
        check(inject ? "R8 stop cell unchanged" : "R3 stop cell held", bad_stop, 0);
        check("R10 done after last write", int'(done_o), 1);
        check("R10 busy low with done", int'(busy_o), 0);
        @(negedge clk);
        check("R10 done single cycle", int'(done_o), 0);
    endtask

    task automatic t_reset();
        check("R1 busy", int'(busy_o), 0);
        check("R1 sampling", int'(sampling_o), 0);
        check("R1 wr_en", int'(wr_en_o), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 stop cell", int'(stop_cell_o), 0);
    endtask

    task automatic t_idle_stop_ignored();
        @(negedge clk); trig_i = 1; soft_stop_i = 1;
        @(negedge clk); trig_i = 0; soft_stop_i = 0;
        check("R11 busy stays low", int'(busy_o), 0);
        check("R11 no write", int'(wr_en_o), 0);
    endtask

    task automatic t_mode0_range();
        cfg_from_stop_i = 0; cfg_keep_run_i = 0; cfg_first_ch_i = 2; cfg_last_ch_i = 4;
        launch(37, 0);
        check("R3 stop cell latched", int'(stop_cell_o), 37);
        check("R3 first channel", int'(wr_ch_o), 2);
        verify_readout(2, 4, 0, 0, 37, 0);
    endtask

    task automatic t_mode1_wrap_keep();
        cfg_from_stop_i = 1; cfg_keep_run_i = 1; cfg_first_ch_i = 8; cfg_last_ch_i = 9;
        launch(1030, 1);
        check("R2 R3 wrapped stop cell", int'(stop_cell_o), 6);
        verify_readout(8, 9, 1, 1, 6, 0);
    endtask

    task automatic t_last_below_first();
        cfg_from_stop_i = 1; cfg_keep_run_i = 0; cfg_first_ch_i = 5; cfg_last_ch_i = 1;
        launch(1023, 0);
        check("R3 stop cell at top", int'(stop_cell_o), 1023);
        verify_readout(5, 5, 1, 0, 1023, 0);
    endtask

    task automatic t_strobes_during_read();
        cfg_from_stop_i = 0; cfg_keep_run_i = 0; cfg_first_ch_i = 0; cfg_last_ch_i = 0;
        launch(500, 0);
        verify_readout(0, 0, 0, 0, 500, 1);
    endtask

    task automatic t_reinit();
        cfg_from_stop_i = 0; cfg_keep_run_i = 1; cfg_first_ch_i = 0; cfg_last_ch_i = 3;
        launch(20, 0);
        repeat (300) @(negedge clk);
        reinit_i = 1;
        @(negedge clk); reinit_i = 0;
        check("R9 busy low after reinit", int'(busy_o), 0);
        check("R9 no write after reinit", int'(wr_en_o), 0);
        check("R9 sampling low", int'(sampling_o), 0);
        check("R9 stop cell kept", int'(stop_cell_o), 20);
        check("R9 no done", int'(done_o), 0);
        @(negedge clk);
        check("R9 no done later", int'(done_o), 0);
        // reinit during sampling
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0; repeat (5) @(negedge clk);
        reinit_i = 1;
        @(negedge clk); reinit_i = 0;
        check("R9 sampling abort", int'(sampling_o), 0);
        check("R9 busy abort", int'(busy_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_idle_stop_ignored();
        t_mode0_range();
        t_mode1_wrap_keep();
        t_last_below_first();
        t_strobes_during_read();
        t_reinit();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule